// File: doc/BRIEF.md
# LIN master header transmitter

This block drives the transmit line of a LIN bus master. One start command sends a whole frame header. The header is a dominant break, a recessive delimiter, the synchronisation byte 0x55 and the protected identifier. The identifier's two parity bits are computed inside the block from the 6-bit identifier that the caller supplies. When the master publishes the response itself, the block goes on to send the data bytes and a classic checksum. When a slave is expected to answer, the block stops after the identifier and pulses a handoff signal, so that a separate receiver can take over.

While it transmits, the block reads the bus back through a two-stage synchroniser. In the middle of every bit, including the break and the delimiter, it compares the bus value with the value it is driving. A mismatch aborts the frame on that very bit. A byte-oriented UART would only report it at the byte boundary. The bit period comes from a baud-rate counter whose limit is chosen by a rate select.

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset, tx_o is 1 (recessive), and busy_o, done_o, handoff_o and bit_err_o are all 0.
- R2: A start accepted while idle drives tx_o low for exactly 13 bit periods, starting on the clock after the start, then high for one delimiter bit period.
- R3: The byte 0x55 follows the delimiter, framed as one low start bit, eight data bits least significant bit first, and one high stop bit.
- R4: The next frame is the protected identifier. Bits 0..5 are id_i, bit 6 is id0^id1^id2^id4, and bit 7 is the inverse of id1^id3^id4^id5. It uses the same framing as R3.
- R5: With publish_i low, the header lasts 34 bit periods. In the clock cycle after the last stop bit ends, done_o and handoff_o are both high for one cycle and busy_o is low.
- R6: With publish_i high, the identifier is followed by the response bytes, byte k taken from data_i[8k+7:8k], and then by one checksum byte. The checksum is the inverted 8-bit sum of the data bytes, with each carry added back in. done_o pulses after the checksum stop bit and handoff_o stays low.
- R7: len_i gives the number of response bytes. Values above MAX_BYTES are treated as MAX_BYTES, and 0 sends only the checksum 0xFF.
- R8: If the synchronised rx_i differs from tx_o at the mid-bit sample (clock count half the bit period), the block releases tx_o high, drops busy_o and pulses done_o one cycle after that sample. bit_err_o rises at the same time and stays high until the next accepted start.
- R9: A start pulse while busy_o is high has no effect on the frame in progress.
- R10: The bit period in clocks is DIV_SLOW for rate_sel_i = 0, DIV_MID for 1, and DIV_FAST for 2 and 3. It is latched at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a frame (sampled only when idle) |
| rate_sel_i | input | 2 | Bit-rate select |
| id_i | input | 6 | Frame identifier |
| len_i | input | $clog2(MAX_BYTES+1) | Number of response bytes |
| data_i | input | 8*MAX_BYTES | Response bytes, byte 0 in the low bits |
| publish_i | input | 1 | 1: master sends the response; 0: hand off after identifier |
| rx_i | input | 1 | Bus read-back from the transceiver |
| tx_o | output | 1 | Bus transmit line, 1 = recessive |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end or abort |
| handoff_o | output | 1 | One-cycle pulse: header sent, slave response expected |
| bit_err_o | output | 1 | Read-back mismatch seen on the last frame |

## Verification
The hardest case to reach is a bit error on one chosen bit in the middle of a frame. On a loop-back bus the read-back always agrees with the drive. The bench therefore lets the bus follow tx_o and, at the start of a chosen recessive bit, forces the bus dominant. This imitates another node that overrides the master. It does this on the delimiter, on the first sync data bit and on the first response data bit. It then checks that busy stays high and the error flag stays low up to the sample cycle, and that the abort shows up exactly one cycle after it. A second start pulse injected in the middle of a frame, with a different identifier, checks that the serialised bits still follow the first command.

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx #(
  parameter int DIV_SLOW  = 20833,
  parameter int DIV_MID   = 5208,
  parameter int DIV_FAST  = 2604,
  parameter int MAX_BYTES = 8,
  localparam int LW   = $clog2(MAX_BYTES + 1),
  localparam int IW   = $clog2(MAX_BYTES + 3),
  localparam int DMAX = (DIV_SLOW > DIV_MID) ? ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST)
                                             : ((DIV_MID > DIV_FAST) ? DIV_MID : DIV_FAST),
  localparam int CW   = $clog2(DMAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [1:0]             rate_sel_i,
  input  logic [5:0]             id_i,
  input  logic [LW-1:0]          len_i,
  input  logic [8*MAX_BYTES-1:0] data_i,
  input  logic                   publish_i,
  input  logic                   rx_i,
  output logic                   tx_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   handoff_o,
  output logic                   bit_err_o
);

  typedef enum logic [1:0] {S_IDLE, S_BRK, S_DEL, S_FRM} st_t;

  st_t                   st;
  logic [CW-1:0]         cyc, div_q, div_sel;
  logic [3:0]            bpos;
  logic [IW-1:0]         idx, last_idx;
  logic [LW-1:0]         len_q;
  logic [8*MAX_BYTES-1:0] dat_q;
  logic [5:0]            id_q;
  logic                  pub_q;
  logic [7:0]            csum, cur_byte, pid;
  logic [8:0]            sum9;
  logic [1:0]            rx_s;
  logic                  done_q, hand_q, err_q;
  logic                  mid, end_bit, fbit;

  always_comb begin
    case (rate_sel_i)
      2'd0:    div_sel = CW'(DIV_SLOW);
      2'd1:    div_sel = CW'(DIV_MID);
      default: div_sel = CW'(DIV_FAST);
    endcase
  end

  assign pid      = {~(id_q[1] ^ id_q[3] ^ id_q[4] ^ id_q[5]),
                     id_q[0] ^ id_q[1] ^ id_q[2] ^ id_q[4], id_q};
  assign last_idx = pub_q ? IW'(len_q) + IW'(2) : IW'(1);
  assign mid      = (cyc == (div_q >> 1));
  assign end_bit  = (cyc == div_q - CW'(1));
  assign sum9     = {1'b0, csum} + {1'b0, cur_byte};

  always_comb begin
    cur_byte = 8'h00;
    if (idx == IW'(0))                 cur_byte = 8'h55;
    else if (idx == IW'(1))            cur_byte = pid;
    else if (idx == last_idx)          cur_byte = ~csum;
    else
      for (int k = 0; k < MAX_BYTES; k++)
        if (idx == IW'(k + 2)) cur_byte = dat_q[8*k +: 8];
  end

  always_comb begin
    if (bpos == 4'd0)      fbit = 1'b0;
    else if (bpos >= 4'd9) fbit = 1'b1;
    else                   fbit = cur_byte[3'(bpos - 4'd1)];
  end

  always_comb begin
    case (st)
      S_BRK:   tx_o = 1'b0;
      S_FRM:   tx_o = fbit;
      default: tx_o = 1'b1;
    endcase
  end

  assign busy_o    = (st != S_IDLE);
  assign done_o    = done_q;
  assign handoff_o = hand_q;
  assign bit_err_o = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cyc    <= '0;
      div_q  <= '0;
      bpos   <= '0;
      idx    <= '0;
      len_q  <= '0;
      dat_q  <= '0;
      id_q   <= '0;
      pub_q  <= 1'b0;
      csum   <= '0;
      rx_s   <= 2'b11;
      done_q <= 1'b0;
      hand_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      rx_s   <= {rx_s[0], rx_i};
      done_q <= 1'b0;
      hand_q <= 1'b0;
      if (st == S_IDLE) begin
        if (start_i) begin
          st    <= S_BRK;
          cyc   <= '0;
          bpos  <= '0;
          idx   <= '0;
          csum  <= '0;
          err_q <= 1'b0;
          div_q <= div_sel;
          id_q  <= id_i;
          pub_q <= publish_i;
          dat_q <= data_i;
          len_q <= (len_i > LW'(MAX_BYTES)) ? LW'(MAX_BYTES) : len_i;
        end
      end else if (mid && (rx_s[1] != tx_o)) begin
        st     <= S_IDLE;
        done_q <= 1'b1;
        err_q  <= 1'b1;
      end else if (end_bit) begin
        cyc <= '0;
        case (st)
          S_BRK: begin
            if (bpos == 4'd12) begin
              st   <= S_DEL;
              bpos <= '0;
            end else bpos <= bpos + 4'd1;
          end
          S_DEL: begin
            st   <= S_FRM;
            bpos <= '0;
            idx  <= '0;
          end
          default: begin
            if (bpos == 4'd9) begin
              if (idx >= IW'(2) && idx != last_idx)
                csum <= sum9[7:0] + {7'd0, sum9[8]};
              if (idx == last_idx) begin
                st     <= S_IDLE;
                done_q <= 1'b1;
                hand_q <= ~pub_q;
              end else begin
                idx  <= idx + IW'(1);
                bpos <= '0;
              end
            end else bpos <= bpos + 4'd1;
          end
        endcase
      end else begin
        cyc <= cyc + CW'(1);
      end
    end
  end

endmodule

// File: rtl/lin_hdr_tx_chk.sv
module lin_hdr_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_o,
  input logic busy_o,
  input logic done_o,
  input logic handoff_o,
  input logic bit_err_o
);

  a_r1_idle_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> tx_o);

  a_r2_break_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !tx_o);

  a_r5_handoff_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    handoff_o |-> (done_o && !bit_err_o && !busy_o));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_error_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_err_o) |-> (done_o && !busy_o && tx_o));

  a_r8_error_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_err_o && !busy_o) |=> (bit_err_o || busy_o));

endmodule

bind lin_hdr_tx lin_hdr_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_o(tx_o), .busy_o(busy_o),
  .done_o(done_o), .handoff_o(handoff_o), .bit_err_o(bit_err_o)
);

// File: tb/tb_lin_hdr_tx.sv
module tb_lin_hdr_tx;
  localparam int D0 = 24, D1 = 12, D2 = 6, MB = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start_i = 1'b0, publish_i = 1'b0;
  logic [1:0]    rate_sel_i = 2'd0;
  logic [5:0]    id_i = '0;
  logic [3:0]    len_i = '0;
  logic [8*MB-1:0] data_i = '0;
  logic          force_dom = 1'b0;
  logic          rx_i, tx_o, busy_o, done_o, handoff_o, bit_err_o;

  assign rx_i = force_dom ? 1'b0 : tx_o;

  lin_hdr_tx #(.DIV_SLOW(D0), .DIV_MID(D1), .DIV_FAST(D2), .MAX_BYTES(MB)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_sel_i(rate_sel_i),
    .id_i(id_i), .len_i(len_i), .data_i(data_i), .publish_i(publish_i),
    .rx_i(rx_i), .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o),
    .handoff_o(handoff_o), .bit_err_o(bit_err_o));

  always #10 clk = ~clk;

  int    checks = 0, errors = 0;
  bit    exp_q[$];
  int    cur_div;
  bit    exp_pub;
  bit    mon_run = 1'b0;
  string done_tag;
  event  kick;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] r);
    return (r == 2'd0) ? D0 : (r == 2'd1) ? D1 : D2;
  endfunction

  task automatic push_byte(input logic [7:0] b);
    exp_q.push_back(1'b0);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
    exp_q.push_back(1'b1);
  endtask

  task automatic build(input logic [5:0] id, input int len, input logic [8*MB-1:0] d,
                       input bit pub);
    logic [7:0] p, cs;
    logic [8:0] s;
    int n;
    for (int i = 0; i < 13; i++) exp_q.push_back(1'b0);
    exp_q.push_back(1'b1);
    push_byte(8'h55);
    p = {~(id[1] ^ id[3] ^ id[4] ^ id[5]), id[0] ^ id[1] ^ id[2] ^ id[4], id};
    push_byte(p);
    if (pub) begin
      n = (len > MB) ? MB : len;
      cs = 8'h00;
      for (int k = 0; k < n; k++) begin
        push_byte(d[8*k +: 8]);
        s = {1'b0, cs} + {1'b0, d[8*k +: 8]};
        cs = s[7:0] + {7'd0, s[8]};
      end
      push_byte(~cs);
    end
  endtask

  // scoreboard monitor: samples tx_o mid-bit and pops expected bits
  initial begin
    forever begin
      int n, h;
      bit e;
      @(kick);
      n = exp_q.size();
      h = cur_div / 2;
      repeat (h + 1) @(posedge clk);
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        e = exp_q.pop_front();
        chk(tx_o === e, (k < 14) ? "R2 break/delim" : (k < 24) ? "R3 sync" :
                        (k < 34) ? "R4 pid" : "R6 response", tx_o, e);
        if (k < n - 1) repeat (cur_div) @(posedge clk);
      end
      repeat (cur_div - h - 1) @(posedge clk);
      @(negedge clk);
      chk(done_o === 1'b1, {done_tag, " done timing"}, done_o, 1);
      chk(handoff_o === !exp_pub, exp_pub ? "R6 no handoff" : "R5 handoff", handoff_o, !exp_pub);
      chk(busy_o === 1'b0 && bit_err_o === 1'b0, "R5 idle after frame",
          {busy_o, bit_err_o}, 0);
      mon_run = 1'b0;
    end
  end

  task automatic run_frame(input logic [1:0] rate, input logic [5:0] id, input int len,
                           input logic [8*MB-1:0] d, input bit pub, input string tag,
                           input bit mid_start);
    cur_div  = div_of(rate);
    exp_pub  = pub;
    done_tag = tag;
    build(id, len, d, pub);
    mon_run = 1'b1;
    @(negedge clk);
    rate_sel_i = rate; id_i = id; len_i = 4'(len); data_i = d; publish_i = pub;
    start_i = 1'b1;
    @(posedge clk);
    ->kick;
    @(negedge clk);
    start_i = 1'b0;
    if (mid_start) begin
      // R9: second start with different settings while busy
      repeat (20 * cur_div) @(negedge clk);
      id_i = ~id; publish_i = ~pub; rate_sel_i = ~rate; len_i = 4'd1;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait (mon_run == 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic err_frame(input logic [1:0] rate, input logic [5:0] id, input bit pub,
                           input logic [8*MB-1:0] d, input int k);
    int dv, h;
    dv = div_of(rate);
    h = dv / 2;
    @(negedge clk);
    rate_sel_i = rate; id_i = id; len_i = 4'd2; data_i = d; publish_i = pub;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    repeat (k * dv) @(negedge clk);
    force_dom = 1'b1;
    repeat (h) @(posedge clk);
    @(negedge clk);
    chk(busy_o === 1'b1 && bit_err_o === 1'b0, "R8 no early abort", {busy_o, bit_err_o}, 2);
    @(posedge clk);
    @(negedge clk);
    chk(done_o === 1'b1 && bit_err_o === 1'b1, "R8 abort on bit", {done_o, bit_err_o}, 3);
    chk(tx_o === 1'b1 && busy_o === 1'b0, "R8 tx released", {tx_o, busy_o}, 2);
    force_dom = 1'b0;
    repeat (3) @(negedge clk);
    chk(bit_err_o === 1'b1 && done_o === 1'b0 && handoff_o === 1'b0, "R8 flag held",
        {bit_err_o, done_o, handoff_o}, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0 && handoff_o === 1'b0
        && bit_err_o === 1'b0, "R1 reset state",
        {tx_o, busy_o, done_o, handoff_o, bit_err_o}, 16);

    run_frame(2'd1, 6'h3C, 0, '0, 1'b0, "R5 R10 mid rate", 1'b0);
    run_frame(2'd0, 6'h01, 2, 64'h0000_0000_0000_A5_17, 1'b1, "R6 R10 slow rate", 1'b0);
    run_frame(2'd2, 6'h2A, 8, 64'hFF_FE_80_81_7F_FF_C3_99, 1'b1, "R6 R10 fast rate", 1'b0);
    run_frame(2'd3, 6'h15, 0, '0, 1'b0, "R10 rate alias", 1'b0);
    run_frame(2'd2, 6'h3F, 0, '0, 1'b1, "R7 zero length", 1'b0);
    run_frame(2'd1, 6'h00, 12, 64'h01_02_03_04_05_06_07_08, 1'b1, "R7 clamp", 1'b0);
    run_frame(2'd1, 6'h12, 3, 64'h0000_0000_00_33_22_11, 1'b1, "R9 busy ignore", 1'b1);

    err_frame(2'd1, 6'h05, 1'b0, '0, 13);
    err_frame(2'd0, 6'h05, 1'b0, '0, 15);
    err_frame(2'd2, 6'h05, 1'b1, 64'h00FF, 35);

    run_frame(2'd2, 6'h21, 1, 64'h5A, 1'b1, "R8 recovery", 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule